// File: doc/BRIEF.md
# Interprocessor Interrupt Command Dispatcher

Each core's local interrupt controller holds one of these blocks. Software puts a command word into a memory-mapped register, and the block turns that one write into a message on the shared inter-core message bus. The message carries a delivery kind, an 8-bit vector and a destination mask with one bit per core. Two kinds of delivery are supported. The first is a reset-style wake message (INIT). The second is a start message, whose vector tells the target core where to begin fetching code.

The message goes out as a direct result of the write to the low command word; no separate trigger is needed. The destination comes from one of two places. A shorthand field in the command word can select every core except the one that issued the command. Otherwise the target core number is read from a companion high-word register, which must be written first. Commands with an unsupported kind or destination are dropped, and they set a sticky error flag.

Control is a two-state machine. IDLE waits for a command. On a legal write to the low command word it takes the LAUNCH transition to SEND. SEND holds the message on the bus. When the bus accepts the message it takes the ACCEPT transition back to IDLE. While the machine is in SEND, the delivery-status bit reads 1.

Top module: `ipi_cmd_dispatch`

## Requirements
- R1: After reset the block is in IDLE with msg_valid=0 and err_flag=0, and both registers read 0.
- R2: A legal write at offset 0x300 in IDLE raises msg_valid in the cycle after the write edge, with no further action.
- R3: While msg_valid=1 and msg_ready=0, msg_valid and all message fields stay stable. After a cycle with msg_ready=1, msg_valid is 0.
- R4: Delivery mode field bits 10:8 = 110 sends a start message: msg_kind=1 and msg_vector = command bits 7:0.
- R5: Delivery mode 101 sends an INIT message: msg_kind=0 and msg_vector=0.
- R6: Shorthand bits 19:18 = 11 sets msg_dest to every core except self_id.
- R7: Shorthand 00 sets msg_dest to the one-hot bit of the core number held in bits 31:24 of the register at offset 0x310.
- R8: A read of 0x300 returns the last accepted low word, with bit 12 set to 1 while a message is pending and 0 otherwise. A read of 0x310 returns the high word.
- R9: A command with any other mode, shorthand 01 or 10, or a core number >= NUM_CORES sends nothing and sets err_flag. err_flag stays set until reset.
- R10: A write to 0x300 while a message is pending is dropped. The register contents and the pending message are unchanged.
- R11: Writes to offsets other than 0x300 and 0x310 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_id | input | CID_W | Number of the issuing core |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write offset inside the controller window |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | 32 | Read data (combinational) |
| msg_valid | output | 1 | Message present on the bus |
| msg_ready | input | 1 | Bus accepts the message |
| msg_kind | output | 1 | 0 = INIT, 1 = start |
| msg_vector | output | 8 | Start vector (0 for INIT) |
| msg_dest | output | NUM_CORES | Destination core mask |
| err_flag | output | 1 | Sticky illegal-command flag |

## Verification
The bench checks that the broadcast mask clears exactly the issuer's bit. A design that included the issuer would wake itself. The bench also holds msg_ready low and issues a second command while one is pending. A design that overwrote the pending command would corrupt a message already on the bus, or lose the status bit. Out-of-range core numbers, reserved shorthands, bad modes and stray offsets are each tried after a fresh reset. A decoder that let any of them through would send a message to the wrong target, or leave the error flag clear.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } ipi_state_e;

    localparam logic [11:0] OFS_CMD_LO = 12'h300;
    localparam logic [11:0] OFS_CMD_HI = 12'h310;
    localparam logic [2:0]  MODE_INIT  = 3'b101;
    localparam logic [2:0]  MODE_START = 3'b110;
    localparam logic [1:0]  SH_NONE    = 2'b00;
    localparam logic [1:0]  SH_OTHERS  = 2'b11;
    localparam int          STATUS_BIT = 12;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int CID_W     = 3
) (
    input  logic [7:0]           vec_field,
    input  logic [2:0]           mode_field,
    input  logic [1:0]           sh_field,
    input  logic [7:0]           target_id,
    input  logic [CID_W-1:0]     self_id,
    output logic                 legal,
    output logic                 kind,
    output logic [7:0]           vector,
    output logic [NUM_CORES-1:0] dest
);
    logic is_init, is_start, sh_none, sh_others, id_ok;

    always_comb begin
        is_init   = (mode_field == MODE_INIT);
        is_start  = (mode_field == MODE_START);
        sh_none   = (sh_field == SH_NONE);
        sh_others = (sh_field == SH_OTHERS);
        id_ok     = (32'(target_id) < NUM_CORES);
        legal     = (is_init || is_start) && (sh_others || (sh_none && id_ok));
        kind      = is_start;
        vector    = is_start ? vec_field : 8'h00;
    end

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_dest
        assign dest[i] = sh_others ? (self_id != CID_W'(i))
                                   : (target_id == 8'(i));
    end
endmodule

// File: rtl/ipi_send_fsm.sv
module ipi_send_fsm
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic                 kind_in,
    input  logic [7:0]           vec_in,
    input  logic [NUM_CORES-1:0] dest_in,
    input  logic                 msg_ready,
    output logic                 msg_valid,
    output logic                 busy,
    output logic                 msg_kind,
    output logic [7:0]           msg_vector,
    output logic [NUM_CORES-1:0] msg_dest
);
    ipi_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch)    state_d = ST_SEND;
            ST_SEND: if (msg_ready) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_kind   <= 1'b0;
            msg_vector <= '0;
            msg_dest   <= '0;
        end else if (launch && state_q == ST_IDLE) begin
            msg_kind   <= kind_in;
            msg_vector <= vec_in;
            msg_dest   <= dest_in;
        end
    end

    always_comb begin
        msg_valid = (state_q == ST_SEND);
        busy      = (state_q == ST_SEND);
    end
endmodule

// File: rtl/ipi_cmd_dispatch.sv
module ipi_cmd_dispatch
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int ADDR_W    = 12,
    localparam int CID_W    = $clog2(NUM_CORES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CID_W-1:0]     self_id,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [31:0]          rd_data,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic                 msg_kind,
    output logic [7:0]           msg_vector,
    output logic [NUM_CORES-1:0] msg_dest,
    output logic                 err_flag
);
    logic [31:0]          lo_q, hi_q;
    logic                 busy, legal, dec_kind;
    logic [7:0]           dec_vec;
    logic [NUM_CORES-1:0] dec_dest;
    logic                 lo_wr, hi_wr, launch;

    assign lo_wr  = wr_en && (wr_addr == ADDR_W'(OFS_CMD_LO)) && !busy;
    assign hi_wr  = wr_en && (wr_addr == ADDR_W'(OFS_CMD_HI));
    assign launch = lo_wr && legal;

    ipi_cmd_decode #(.NUM_CORES(NUM_CORES), .CID_W(CID_W)) u_dec (
        .vec_field  (wr_data[7:0]),
        .mode_field (wr_data[10:8]),
        .sh_field   (wr_data[19:18]),
        .target_id  (hi_q[31:24]),
        .self_id    (self_id),
        .legal      (legal),
        .kind       (dec_kind),
        .vector     (dec_vec),
        .dest       (dec_dest)
    );

    ipi_send_fsm #(.NUM_CORES(NUM_CORES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .kind_in    (dec_kind),
        .vec_in     (dec_vec),
        .dest_in    (dec_dest),
        .msg_ready  (msg_ready),
        .msg_valid  (msg_valid),
        .busy       (busy),
        .msg_kind   (msg_kind),
        .msg_vector (msg_vector),
        .msg_dest   (msg_dest)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q     <= '0;
            hi_q     <= '0;
            err_flag <= 1'b0;
        end else begin
            if (lo_wr) begin
                lo_q             <= wr_data;
                lo_q[STATUS_BIT] <= 1'b0;
            end
            if (hi_wr)            hi_q     <= wr_data;
            if (lo_wr && !legal)  err_flag <= 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_CMD_LO)) begin
            rd_data             = lo_q;
            rd_data[STATUS_BIT] = busy;
        end else if (rd_addr == ADDR_W'(OFS_CMD_HI)) begin
            rd_data = hi_q;
        end
    end
endmodule

// File: rtl/ipi_cmd_dispatch_chk.sv
module ipi_cmd_dispatch_chk #(
    parameter int NUM_CORES = 8,
    parameter int ADDR_W    = 12,
    parameter int CID_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CID_W-1:0]     self_id,
    input logic [ADDR_W-1:0]    rd_addr,
    input logic [31:0]          rd_data,
    input logic                 msg_valid,
    input logic                 msg_ready,
    input logic                 msg_kind,
    input logic [7:0]           msg_vector,
    input logic [NUM_CORES-1:0] msg_dest,
    input logic                 err_flag
);
    AST_HOLD_UNTIL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) && $stable(msg_vector) && $stable(msg_dest)); // R3
    AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready |=> !msg_valid); // R3
    AST_INIT_ZERO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_kind |-> msg_vector == 8'h00); // R5
    AST_BCAST_SKIPS_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && ($countones(msg_dest) > 1) |-> !msg_dest[self_id]); // R6
    AST_DEST_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_dest != '0); // R7
    AST_STATUS_TRACKS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr == ADDR_W'(12'h300) |-> rd_data[12] == msg_valid); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R9
endmodule

bind ipi_cmd_dispatch ipi_cmd_dispatch_chk #(
    .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .CID_W(CID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .self_id(self_id), .rd_addr(rd_addr),
    .rd_data(rd_data), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_kind(msg_kind), .msg_vector(msg_vector), .msg_dest(msg_dest),
    .err_flag(err_flag)
);

// File: tb/ipi_cmd_dispatch_test.sv
module ipi_cmd_dispatch_test;
    localparam int NC = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  self_id = 3'd2;
    logic        wr_en = 0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        msg_valid, msg_ready = 0, msg_kind, err_flag;
    logic [7:0]  msg_vector;
    logic [NC-1:0] msg_dest;

    int total = 0, bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ipi_cmd_dispatch #(.NUM_CORES(NC), .ADDR_W(12)) uut (
        .clk(clk), .rst_n(rst_n), .self_id(self_id), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_kind(msg_kind), .msg_vector(msg_vector), .msg_dest(msg_dest),
        .err_flag(err_flag)
    );

    typedef struct packed {
        logic [31:0] hi;
        logic [31:0] lo;
        logic        ev;
        logic        ek;
        logic [7:0]  evec;
        logic [7:0]  edest;
        logic        eerr;
    } vec_t;

    // R4 R5 R6 R7 R9 table; self_id = 2
    localparam vec_t TBL [6] = '{
        '{32'h0000_0000, 32'h000C_4500, 1'b1, 1'b0, 8'h00, 8'hFB, 1'b0},
        '{32'h0000_0000, 32'h000C_4612, 1'b1, 1'b1, 8'h12, 8'hFB, 1'b0},
        '{32'h0500_0000, 32'h0000_4634, 1'b1, 1'b1, 8'h34, 8'h20, 1'b0},
        '{32'h0000_0000, 32'h0000_4500, 1'b1, 1'b0, 8'h00, 8'h01, 1'b0},
        '{32'h0700_0000, 32'h0000_467F, 1'b1, 1'b1, 8'h7F, 8'h80, 1'b0},
        '{32'h0000_0000, 32'h000C_4300, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic accept();
        @(negedge clk);
        msg_ready = 1;
        @(negedge clk);
        msg_ready = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        logic [31:0] r;
        do_reset();
        // R1 reset state
        check("R1 valid", 32'(msg_valid), 0);
        check("R1 err", 32'(err_flag), 0);
        rd(12'h300, r); check("R1 lo", r, 0);
        rd(12'h310, r); check("R1 hi", r, 0);

        for (int i = 0; i < 6; i++) begin
            wr(12'h310, TBL[i].hi);
            wr(12'h300, TBL[i].lo);
            check("R2 valid", 32'(msg_valid), 32'(TBL[i].ev));
            check("R9 err", 32'(err_flag), 32'(TBL[i].eerr));
            if (TBL[i].ev) begin
                check("R4 R5 kind", 32'(msg_kind), 32'(TBL[i].ek));
                check("R4 R5 vector", 32'(msg_vector), 32'(TBL[i].evec));
                check("R6 R7 dest", 32'(msg_dest), 32'(TBL[i].edest));
                rd(12'h300, r); check("R8 pending", r, TBL[i].lo | 32'h1000);
                rd(12'h310, r); check("R8 hi", r, TBL[i].hi);
                accept();
                check("R3 drop", 32'(msg_valid), 0);
                rd(12'h300, r); check("R8 done", r, TBL[i].lo);
            end
        end

        // R3 R10: hold while pending, second write dropped
        do_reset();
        wr(12'h300, 32'h000C_4656);
        repeat (3) @(negedge clk);
        check("R3 hold", 32'(msg_valid), 1);
        wr(12'h300, 32'h000C_4699);
        check("R10 vector", 32'(msg_vector), 32'h56);
        rd(12'h300, r); check("R10 reg", r, 32'h000C_5656);
        accept();
        check("R3 drop", 32'(msg_valid), 0);
        @(negedge clk);
        check("R10 no resend", 32'(msg_valid), 0);

        // R9 reserved shorthand
        do_reset();
        wr(12'h300, 32'h0004_4612);
        check("R9 sh01 valid", 32'(msg_valid), 0);
        check("R9 sh01 err", 32'(err_flag), 1);
        // R9 core number out of range
        do_reset();
        wr(12'h310, 32'h0800_0000);
        wr(12'h300, 32'h0000_4612);
        check("R9 id valid", 32'(msg_valid), 0);
        check("R9 id err", 32'(err_flag), 1);
        repeat (3) @(negedge clk);
        check("R9 sticky", 32'(err_flag), 1);

        // R11 stray offset
        do_reset();
        wr(12'h304, 32'h000C_4612);
        check("R11 valid", 32'(msg_valid), 0);
        check("R11 err", 32'(err_flag), 0);
        rd(12'h300, r); check("R11 lo", r, 0);
        rd(12'h310, r); check("R11 hi", r, 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule